// File: doc/BRIEF.md
# Open-Page DRAM Bank Command Sequencer

This block sits between a request source and a DRAM command bus. Each request names a bank, a row and a column, and says whether it reads or writes. The block keeps a small table that records, for every bank, whether a row is open and which row that is. It then emits the shortest legal command sequence for the request under an open-page policy. A request that targets the row already open in its bank goes straight out as a column command. A request to a closed bank first opens the row. A request to a different row in an open bank first closes that row and then opens the new one. Row addresses travel with the open command and column addresses travel with the read or write command, so the two share one address bus.

Timing is counted in clock cycles. The block waits out each of these gaps: open-to-column, close-to-open, column-to-column (one burst), and write recovery before a later read or close. For every read it raises a data-valid strobe once the CAS latency has passed. The strobe stays high for one burst, and a second output gives the column of each beat.

Requests enter on a valid/ready handshake. The block takes a request only in a cycle where both `req_valid` and `req_ready` are high. It drops `req_ready` until that request's column command has gone out, so requests are served one at a time and in order. While `req_ready` is low the block does not look at the request fields or `req_valid`, and the source may change them freely. There is no back-pressure on the command side.

Top module: `dram_page_seq`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `cmd_code` is NOP (0), `rd_valid` is 0, and every bank is recorded as closed.
- R2: `cmd_code` only ever carries NOP=0, ACT=1 (open row), PRE=2 (close row), RD=3 or WR=4. At most one command goes out per cycle.
- R3: The first access to a closed bank issues ACT and then the column command, with no PRE.
- R4: An access to the row already open in its bank issues only the column command. If no timing limit is pending, it goes out in the cycle after acceptance.
- R5: An access to another row of an open bank issues PRE, then ACT, then the column command. ACT comes no sooner than T_RP cycles after PRE, and the column command no sooner than T_RCD cycles after ACT.
- R6: `cmd_bank` carries the request's bank. `cmd_addr` carries the row with ACT, the zero-extended column with RD and WR, and 0 with PRE.
- R7: After an RD issued in cycle r, `rd_valid` is high in cycles r+CAS_LAT through r+CAS_LAT+BURST_LEN-1. In those cycles `rd_col` steps from the request column by one per beat, wrapping modulo 2^COL_W.
- R8: An RD or PRE is issued no sooner than T_WR cycles after the most recent WR.
- R9: Column commands (RD or WR) are at least BURST_LEN cycles apart. BURST_LEN is 4 or 8.
- R10: `req_ready` is low from the cycle after acceptance until the request's column command has been issued. Every command goes out while `req_ready` is low, and each command happens at the earliest cycle that the limits in R4, R5, R8 and R9 allow.
- R11: Opening or closing a row in one bank leaves the open-row state of every other bank unchanged.
- R12: While `req_ready` is low, `req_valid` and the request fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | First column of the burst |
| cmd_code | output | 3 | Command: NOP 0, ACT 1, PRE 2, RD 3, WR 4 |
| cmd_bank | output | BANK_W | Bank the command addresses |
| cmd_addr | output | ADDR_W | Row for ACT, column for RD/WR, 0 for PRE |
| rd_valid | output | 1 | Read data beat is valid this cycle |
| rd_col | output | COL_W | Column of the current read beat |

## Verification
A bad entry in the open-row table shows up at the ports on the first command of the next request to that bank. If the table wrongly says the row is open, ACT is missing. If it wrongly says the bank is closed, PRE is missing. A stale row value produces an extra or missing PRE and ACT pair. Any of these appears within one cycle of acceptance. A countdown that is off by even one cycle moves a PRE, ACT or column command by that cycle against the earliest legal slot, so the bench compares command cycles exactly rather than against bounds. A fault in the read delay line shows CAS_LAT cycles later, as a valid strobe or beat column in the wrong cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLOSE = 2'd1,
    ST_OPEN  = 2'd2,
    ST_COL   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dram_countdown.sv
module dram_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_open,
  output logic              lk_hit,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic              upd_open,
  input  logic              upd_close,
  input  logic [ROW_W-1:0]  upd_row
);

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (upd_bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (sel && upd_open) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row;
      end else if (sel && upd_close) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign lk_open = open_q[lk_bank];
  assign lk_hit  = lk_open && (row_q[lk_bank] == lk_row);

endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
  parameter int CAS_LAT   = 9,
  parameter int BURST_LEN = 8,
  parameter int COL_W     = 8,
  localparam int BCW      = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [COL_W-1:0] rd_col_in,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col
);

  logic [CAS_LAT-1:0] vld_d;
  logic [COL_W-1:0]   col_d [CAS_LAT];

  for (genvar i = 0; i < CAS_LAT; i++) begin : g_stage
    logic             vin;
    logic [COL_W-1:0] cin;
    if (i == 0) begin : g_first
      assign vin = rd_fire;
      assign cin = rd_col_in;
    end else begin : g_next
      assign vin = vld_d[i-1];
      assign cin = col_d[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_d[i] <= 1'b0;
        col_d[i] <= '0;
      end else begin
        vld_d[i] <= vin;
        col_d[i] <= cin;
      end
    end
  end

  logic             first_beat;
  logic [COL_W-1:0] first_col;
  logic [BCW-1:0]   beats_left_q;
  logic [COL_W-1:0] next_col_q;

  assign first_beat = vld_d[CAS_LAT-1];
  assign first_col  = col_d[CAS_LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_left_q <= '0;
      next_col_q   <= '0;
    end else if (first_beat) begin
      beats_left_q <= BCW'(BURST_LEN - 1);
      next_col_q   <= first_col + 1'b1;
    end else if (beats_left_q != '0) begin
      beats_left_q <= beats_left_q - 1'b1;
      next_col_q   <= next_col_q + 1'b1;
    end
  end

  assign rd_valid = first_beat || (beats_left_q != '0);
  assign rd_col   = first_beat ? first_col : next_col_q;

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int CAS_LAT   = 9,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_valid,
  output logic [COL_W-1:0]  rd_col
);

  localparam int DLY_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int WR_W    = $clog2(T_WR + 1);
  localparam int CC_W    = $clog2(BURST_LEN + 1);

  seq_state_e        state_q, state_n;
  logic              cur_write;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;

  logic accept;
  logic lk_open, lk_hit;
  logic dly_zero, wr_zero, cc_zero;
  logic close_go, open_go, col_go;
  cmd_e cmd_n;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Per-bank open-row state, looked up with the incoming request.
  dram_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) bank_tbl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_bank   (req_bank),
    .lk_row    (req_row),
    .lk_open   (lk_open),
    .lk_hit    (lk_hit),
    .upd_bank  (cur_bank),
    .upd_open  (open_go),
    .upd_close (close_go),
    .upd_row   (cur_row)
  );

  // Row-cycle delay: close-to-open and open-to-column share one counter.
  dram_countdown #(.W(DLY_W)) dly_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (close_go || open_go),
    .load_val (close_go ? DLY_W'(T_RP - 1) : DLY_W'(T_RCD - 1)),
    .zero     (dly_zero)
  );

  // Write recovery guard for later RD and PRE.
  dram_countdown #(.W(WR_W)) wr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (col_go && cur_write),
    .load_val (WR_W'(T_WR - 1)),
    .zero     (wr_zero)
  );

  // Column-to-column spacing of one burst.
  dram_countdown #(.W(CC_W)) cc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (col_go),
    .load_val (CC_W'(BURST_LEN - 1)),
    .zero     (cc_zero)
  );

  assign close_go = (state_q == ST_CLOSE) && wr_zero;
  assign open_go  = (state_q == ST_OPEN) && dly_zero;
  assign col_go   = (state_q == ST_COL) && dly_zero && cc_zero &&
                    (cur_write || wr_zero);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (lk_hit)       state_n = ST_COL;
          else if (lk_open) state_n = ST_CLOSE;
          else              state_n = ST_OPEN;
        end
      end
      ST_CLOSE: if (close_go) state_n = ST_OPEN;
      ST_OPEN:  if (open_go)  state_n = ST_COL;
      ST_COL:   if (col_go)   state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_write <= 1'b0;
      cur_bank  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
    end else begin
      state_q <= state_n;
      if (accept) begin
        cur_write <= req_write;
        cur_bank  <= req_bank;
        cur_row   <= req_row;
        cur_col   <= req_col;
      end
    end
  end

  always_comb begin
    cmd_n    = CMD_NOP;
    cmd_addr = '0;
    if (close_go) begin
      cmd_n = CMD_PRE;
    end else if (open_go) begin
      cmd_n    = CMD_ACT;
      cmd_addr = ADDR_W'(cur_row);
    end else if (col_go) begin
      cmd_n    = cur_write ? CMD_WR : CMD_RD;
      cmd_addr = ADDR_W'(cur_col);
    end
  end

  assign cmd_code = cmd_n;
  assign cmd_bank = cur_bank;

  dram_rd_pipe #(
    .CAS_LAT   (CAS_LAT),
    .BURST_LEN (BURST_LEN),
    .COL_W     (COL_W)
  ) rd_pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (col_go && !cur_write),
    .rd_col_in (cur_col),
    .rd_valid  (rd_valid),
    .rd_col    (rd_col)
  );

endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
  parameter int CAS_LAT   = 9,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] cmd_code,
  input logic       rd_valid
);

  localparam logic [15:0] L_RP  = 16'(T_RP);
  localparam logic [15:0] L_RCD = 16'(T_RCD);
  localparam logic [15:0] L_WR  = 16'(T_WR);
  localparam logic [15:0] L_BL  = 16'(BURST_LEN);
  localparam logic [15:0] L_CL  = 16'(CAS_LAT);
  localparam logic [15:0] L_CLE = 16'(CAS_LAT + BURST_LEN - 1);

  logic is_act, is_pre, is_rd, is_wr, is_col;
  assign is_act = (cmd_code == 3'd1);
  assign is_pre = (cmd_code == 3'd2);
  assign is_rd  = (cmd_code == 3'd3);
  assign is_wr  = (cmd_code == 3'd4);
  assign is_col = is_rd || is_wr;

  // Cycles since the last event; saturate, start far in the past.
  logic [15:0] since_pre, since_act, since_wr, since_col, since_rd, since_rd2;

  function automatic logic [15:0] bump(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= 16'hFFFF;
      since_act <= 16'hFFFF;
      since_wr  <= 16'hFFFF;
      since_col <= 16'hFFFF;
      since_rd  <= 16'hFFFF;
      since_rd2 <= 16'hFFFF;
    end else begin
      since_pre <= is_pre ? 16'd1 : bump(since_pre);
      since_act <= is_act ? 16'd1 : bump(since_act);
      since_wr  <= is_wr  ? 16'd1 : bump(since_wr);
      since_col <= is_col ? 16'd1 : bump(since_col);
      if (is_rd) begin
        since_rd  <= 16'd1;
        since_rd2 <= bump(since_rd);
      end else begin
        since_rd  <= bump(since_rd);
        since_rd2 <= bump(since_rd2);
      end
    end
  end

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code <= 3'd4);

  p_act_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre >= L_RP);

  p_col_after_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act >= L_RCD);

  p_wr_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_pre) |-> since_wr >= L_WR);

  p_col_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_col >= L_BL);

  p_cmd_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != 3'd0) |-> !req_ready);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rd_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((since_rd >= L_CL && since_rd <= L_CLE) ||
                  (since_rd2 >= L_CL && since_rd2 <= L_CLE)));

endmodule

bind dram_page_seq dram_page_seq_chk #(
  .CAS_LAT   (CAS_LAT),
  .BURST_LEN (BURST_LEN),
  .T_RCD     (T_RCD),
  .T_RP      (T_RP),
  .T_WR      (T_WR)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_code  (cmd_code),
  .rd_valid  (rd_valid)
);

// File: tb/dram_page_seq_tb.sv
module dram_page_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB     = 4;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 8;
  localparam int ADDR_W = 12;
  localparam int CL     = 9;
  localparam int BL     = 8;
  localparam int TRCD   = 3;
  localparam int TRP    = 3;
  localparam int TWR    = 10;
  localparam int QN     = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [2:0]        cmd_code;
  logic [BANK_W-1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;
  logic              rd_valid;
  logic [COL_W-1:0]  rd_col;

  dram_page_seq #(
    .NUM_BANKS (NB), .ROW_W (ROW_W), .COL_W (COL_W), .CAS_LAT (CL),
    .BURST_LEN (BL), .T_RCD (TRCD), .T_RP (TRP), .T_WR (TWR)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_bank (req_bank), .req_row (req_row),
    .req_col (req_col), .cmd_code (cmd_code), .cmd_bank (cmd_bank),
    .cmd_addr (cmd_addr), .rd_valid (rd_valid), .rd_col (rd_col)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
               tag, what, cyc, act, exp);
    end
  endtask

  // Expected command queue (filled by the driver, drained by the monitor).
  int    q_code [QN];
  int    q_bank [QN];
  int    q_addr [QN];
  string q_tag  [QN];
  int    q_head = 0;
  int    q_tail = 0;
  int    seq_base = 0;

  // Reference open-row table.
  bit m_open [NB];
  int m_row  [NB];

  function automatic void push(input int code, input int bank,
                               input int addr, input string tag);
    q_code[q_tail % QN] = code;
    q_bank[q_tail % QN] = bank;
    q_addr[q_tail % QN] = addr;
    q_tag[q_tail % QN]  = tag;
    q_tail++;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Monitor state.
  int last_pre = -1000, last_act = -1000, last_wr = -1000, last_col = -1000;
  int mon_last = -1000;
  int n_cmds = 0;
  bit             ev_v [64];
  logic [COL_W-1:0] ev_c [64];
  int pending = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
      chk(cmd_code == 3'd0, "R1", "cmd in reset", int'(cmd_code), 0);
      chk(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
    end else begin
      chk(cmd_code <= 3'd4, "R2", "command code legal", int'(cmd_code), 0);
      if (cmd_code != 3'd0) begin
        int code, base, earliest, slot;
        string tag;
        n_cmds++;
        code = int'(cmd_code);
        chk(req_ready == 1'b0, "R10", "ready low while issuing", int'(req_ready), 0);
        if (q_head == q_tail) begin
          chk(1'b0, "R10", "unexpected command", code, 0);
        end else begin
          tag = q_tag[q_head % QN];
          chk(code == q_code[q_head % QN], tag, "command code",
              code, q_code[q_head % QN]);
          chk(int'(cmd_bank) == q_bank[q_head % QN], "R6", "command bank",
              int'(cmd_bank), q_bank[q_head % QN]);
          chk(int'(cmd_addr) == q_addr[q_head % QN], "R6", "command address",
              int'(cmd_addr), q_addr[q_head % QN]);
          q_head++;
        end
        base = imax(seq_base, mon_last + 1);
        earliest = base;
        case (code)
          2: earliest = imax(base, last_wr + TWR);
          1: earliest = imax(base, last_pre + TRP);
          3: earliest = imax(imax(base, last_act + TRCD),
                             imax(last_col + BL, last_wr + TWR));
          4: earliest = imax(imax(base, last_act + TRCD), last_col + BL);
          default: earliest = base;
        endcase
        case (code)
          2: chk(cyc == earliest, "R8", "PRE cycle", cyc, earliest);
          1: chk(cyc == earliest, "R5", "ACT cycle", cyc, earliest);
          default: chk(cyc == earliest, "R9", "column cycle (R4 R5 R8)", cyc, earliest);
        endcase
        mon_last = cyc;
        if (code == 2) last_pre = cyc;
        if (code == 1) last_act = cyc;
        if (code == 3 || code == 4) last_col = cyc;
        if (code == 4) last_wr = cyc;
        if (code == 3) begin
          for (int k = 0; k < BL; k++) begin
            slot = (cyc + CL + k) % 64;
            ev_v[slot] = 1'b1;
            ev_c[slot] = COL_W'(cmd_addr) + COL_W'(k);
            pending++;
          end
        end
      end
      begin
        int s;
        s = cyc % 64;
        chk(rd_valid == ev_v[s], "R7", "rd_valid", int'(rd_valid), int'(ev_v[s]));
        if (ev_v[s]) begin
          chk(rd_col == ev_c[s], "R7", "rd_col", int'(rd_col), int'(ev_c[s]));
          ev_v[s] = 1'b0;
          pending--;
        end
      end
    end
  end

  // Drive one request; afterwards put junk on the request pins (R12).
  task automatic send(input bit wr, input int bank, input int row,
                      input int col, input string hit_tag);
    int col_code;
    do begin
      @(negedge clk);
      #1;
    end while (!req_ready);
    req_valid = 1'b1;
    req_write = wr;
    req_bank  = BANK_W'(bank);
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    col_code  = wr ? 4 : 3;
    if (m_open[bank] && m_row[bank] == row) begin
      push(col_code, bank, col, (hit_tag != "") ? hit_tag : "R4");
    end else if (m_open[bank]) begin
      push(2, bank, 0, "R5");
      push(1, bank, row, "R5");
      push(col_code, bank, col, "R5");
    end else begin
      push(1, bank, row, "R3");
      push(col_code, bank, col, "R3");
    end
    m_open[bank] = 1'b1;
    m_row[bank]  = row;
    seq_base = cyc + 1;
    @(posedge clk);
    #1;
    // R12: while busy, pins carry values that must not be taken.
    req_valid = 1'b1;
    req_write = 1'($urandom_range(0, 1));
    req_bank  = BANK_W'($urandom_range(0, NB - 1));
    req_row   = ROW_W'($urandom_range(0, 4095));
    req_col   = COL_W'($urandom_range(0, 255));
  endtask

  bit done = 1'b0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R10", "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 1'b0;
      m_row[b]  = 0;
    end
    for (int s = 0; s < 64; s++) ev_v[s] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;

    // Directed corner cases.
    send(1'b0, 0, 5, 8'h10, "");   // R3 closed bank
    send(1'b0, 0, 5, 8'h20, "");   // R4 page hit, spaced by R9
    send(1'b1, 0, 5, 8'h30, "");   // write hit
    send(1'b0, 0, 5, 8'h40, "R8"); // read held by write recovery
    send(1'b1, 0, 7, 8'h50, "");   // R5 miss
    send(1'b0, 0, 9, 8'h60, "");   // R8 PRE held by recovery
    send(1'b1, 1, 2, 8'h70, "");   // R3 other bank
    send(1'b0, 0, 9, 8'h80, "R11"); // bank 0 still open after bank 1 opened
    send(1'b0, 2, 3, 8'hFE, "");   // R7 beat column wrap
    send(1'b0, 2, 3, 8'hFA, "R4");

    // Constrained random traffic.
    for (int n = 0; n < 300; n++) begin
      send($urandom_range(0, 9) < 3, $urandom_range(0, NB - 1),
           $urandom_range(0, 3), $urandom_range(0, 255), "");
    end

    do begin
      @(negedge clk);
      #1;
    end while (!req_ready);
    req_valid = 1'b0;
    repeat (CL + BL + 20) @(negedge clk);
    chk(q_head == q_tail, "R12", "all expected commands issued, junk ignored",
        q_tail - q_head, 0);
    chk(n_cmds == q_tail, "R10", "command count", n_cmds, q_tail);
    chk(pending == 0, "R7", "read beats outstanding", pending, 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule